// File: doc/BRIEF.md
# Bus-Scanning Memory Port Selector

This block sits on the memory side of a read-only interconnect in which several buses can each carry a read request towards any of a set of memory modules. While idle, the port looks at every bus at once and picks one whose request line is high and whose memory number equals this module's own number. It then latches that bus's word address, issues one read to a local synchronous memory, and returns the word with a ready flag on the chosen bus only. It holds the word there until the requester drops its request, and then goes back to scanning.

Buses can never write through this port. The local processor's write path lives outside the block. If a requester holds the port busy for too long, a watchdog breaks the connection. With lockout enabled, that bus is ignored from then on, until the next reset. Fairness between simultaneous requesters comes from a round-robin scan that starts one position after the bus served last.

Top module: `mem_port_selector`

## Requirements
- R1: During and right after reset, every bit of `bus_ready`, `bus_rdata` and `mem_rd_en` is 0.
- R2: A bus is served only when its `bus_req` bit is 1 and its `bus_mem_id` field equals `my_id`. Other buses get no ready and cause no memory read.
- R3: After the edge that grants a bus, `mem_rd_en` is high for the next cycle, and ready rises on the third edge counted from the grant edge. Bus i's data field (`bus_rdata[i*DATA_W +: DATA_W]`) then carries the memory word at the granted address.
- R4: Each grant produces exactly one single-cycle `mem_rd_en` pulse. Its address is `bus_addr` as sampled at the grant edge, so later changes of that bus's address have no effect.
- R5: While the served bus keeps its request high, its ready bit stays at 1 and its data stays stable. All other buses see ready 0 and data 0.
- R6: When the served bus drops its request, its ready falls at the next edge and the port can accept a new request at the edge after that.
- R7: Among simultaneous eligible requests, the port grants the first bus at or after (last served + 1), modulo `NUM_BUS`. After reset, the scan starts at bus 0.
- R8: The port is never busy for more than `TIMEOUT_CYC` consecutive cycles. After that it releases the bus, drops ready and resumes scanning.
- R9: With `LOCKOUT_EN` set, a bus that timed out is never granted again, while other buses are still served.
- R10: Reset clears every lockout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| my_id | input | ID_W | Module number this port answers to |
| bus_req | input | NUM_BUS | Read request line of each bus |
| bus_mem_id | input | NUM_BUS*ID_W | Target memory number carried by each bus |
| bus_addr | input | NUM_BUS*ADDR_W | Word address carried by each bus |
| bus_rdata | output | NUM_BUS*DATA_W | Returned word, driven on the served bus only |
| bus_ready | output | NUM_BUS | Data-ready flag, one-hot or zero |
| mem_rd_en | output | 1 | Read strobe to the local memory |
| mem_addr | output | ADDR_W | Read address to the local memory |
| mem_rdata | input | DATA_W | Local memory read data, one cycle after the strobe |

## Verification
The assertions take for granted three things about the inputs. Inputs change only between clock edges. The local memory answers exactly one cycle after the strobe. `TIMEOUT_CYC` is at least 4, so the three-cycle answer path always completes before the watchdog fires. The stimulus drives every input on the falling edge, and its memory model registers data one edge after `mem_rd_en`. It keeps the default timeout of 16. Each request stays high until the bench has seen its ready, or until it deliberately overstays to provoke the watchdog.

// File: rtl/mps_pkg.sv
// Shared types for the bus-scanning memory port selector.
package mps_pkg;
    typedef enum logic [1:0] {
        ST_SCAN = 2'd0,   // idle, looking for a matching request
        ST_READ = 2'd1,   // strobe issued to local memory
        ST_WAIT = 2'd2,   // memory data arrives this cycle
        ST_HOLD = 2'd3    // data and ready presented on the bus
    } mps_state_e;
endpackage

// File: rtl/mps_id_match.sv
// Per-bus eligibility: request high, memory number equal to ours, bus not locked.
// Assumes the ID fields are packed with bus 0 in the least significant position.
module mps_id_match #(
    parameter int NB   = 4,
    parameter int ID_W = 3
) (
    input  logic [ID_W-1:0]    my_id,
    input  logic [NB-1:0]      req,
    input  logic [NB*ID_W-1:0] mem_id,
    input  logic [NB-1:0]      lock,
    output logic [NB-1:0]      hit
);
    for (genvar i = 0; i < NB; i++) begin : g_cmp
        // Compare one bus's target number with our own.
        assign hit[i] = req[i] && !lock[i] && (mem_id[i*ID_W +: ID_W] == my_id);
    end
endmodule

// File: rtl/mps_rr_pick.sv
// Round-robin picker: returns the first set bit at or after last+1, wrapping.
// Assumes last is a valid bus index below NB.
module mps_rr_pick #(
    parameter int NB   = 4,
    parameter int IW   = 2
) (
    input  logic [NB-1:0] elig,
    input  logic [IW-1:0] last,
    output logic          any,
    output logic [IW-1:0] pick
);
    // Walk the buses in rotated order and keep the first eligible one.
    always_comb begin
        any  = 1'b0;
        pick = '0;
        for (int k = 1; k <= NB; k++) begin
            int idx;
            idx = (int'(last) + k) % NB;
            if (!any && elig[idx]) begin
                any  = 1'b1;
                pick = IW'(idx);
            end
        end
    end
endmodule

// File: rtl/mps_busy_guard.sv
// Busy watchdog: counts consecutive busy cycles and flags the last allowed one.
// Assumes busy goes low for at least one cycle between connections.
module mps_busy_guard #(
    parameter int TIMEOUT_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    output logic expire
);
    localparam int CW = $clog2(TIMEOUT_CYC + 1);
    logic [CW-1:0] cnt_q;

    // Count cycles spent busy, restart whenever the port is idle.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (!busy) cnt_q <= '0;
        else            cnt_q <= cnt_q + 1'b1;
    end

    assign expire = busy && (cnt_q == CW'(TIMEOUT_CYC - 1));
endmodule

// File: rtl/mem_port_selector.sv
// Memory-side port of a multi-bus read interconnect.
// Scans all buses, grants one matching request round-robin, performs one read
// of the local memory (one-cycle latency) and holds data/ready on that bus
// until the request drops. A watchdog releases a bus that holds too long and
// can lock it out until reset. Buses have no write access.
module mem_port_selector #(
    parameter int NUM_BUS     = 4,
    parameter int ID_W        = 3,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    parameter int TIMEOUT_CYC = 16,
    parameter bit LOCKOUT_EN  = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ID_W-1:0]           my_id,
    input  logic [NUM_BUS-1:0]        bus_req,
    input  logic [NUM_BUS*ID_W-1:0]   bus_mem_id,
    input  logic [NUM_BUS*ADDR_W-1:0] bus_addr,
    output logic [NUM_BUS*DATA_W-1:0] bus_rdata,
    output logic [NUM_BUS-1:0]        bus_ready,
    output logic                      mem_rd_en,
    output logic [ADDR_W-1:0]         mem_addr,
    input  logic [DATA_W-1:0]         mem_rdata
);
    import mps_pkg::*;

    localparam int IW = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1;

    mps_state_e          state_q;
    logic [IW-1:0]       sel_q;
    logic [IW-1:0]       last_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   data_q;
    logic                rdy_q;
    logic [NUM_BUS-1:0]  lock_q;
    logic [NUM_BUS-1:0]  hit;
    logic                any_hit;
    logic [IW-1:0]       pick;
    logic                busy;
    logic                expire;
    logic                sel_req;

    mps_id_match #(.NB(NUM_BUS), .ID_W(ID_W)) u_match (
        .my_id  (my_id),
        .req    (bus_req),
        .mem_id (bus_mem_id),
        .lock   (lock_q),
        .hit    (hit)
    );

    mps_rr_pick #(.NB(NUM_BUS), .IW(IW)) u_pick (
        .elig (hit),
        .last (last_q),
        .any  (any_hit),
        .pick (pick)
    );

    assign busy = (state_q != ST_SCAN);

    mps_busy_guard #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_guard (
        .clk    (clk),
        .rst_n  (rst_n),
        .busy   (busy),
        .expire (expire)
    );

    assign sel_req = bus_req[sel_q];

    // Connection state machine: scan, read, capture, hold, release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SCAN;
            sel_q   <= '0;
            last_q  <= IW'(NUM_BUS - 1);
            addr_q  <= '0;
            data_q  <= '0;
            rdy_q   <= 1'b0;
            lock_q  <= '0;
        end else if (state_q == ST_SCAN) begin
            if (any_hit) begin
                state_q <= ST_READ;
                sel_q   <= pick;
                last_q  <= pick;
                addr_q  <= bus_addr[pick*ADDR_W +: ADDR_W];
            end
        end else if (!sel_req) begin
            state_q <= ST_SCAN;
            rdy_q   <= 1'b0;
        end else if (expire) begin
            state_q <= ST_SCAN;
            rdy_q   <= 1'b0;
            if (LOCKOUT_EN) lock_q[sel_q] <= 1'b1;
        end else begin
            case (state_q)
                ST_READ: state_q <= ST_WAIT;
                ST_WAIT: begin
                    data_q  <= mem_rdata;
                    rdy_q   <= 1'b1;
                    state_q <= ST_HOLD;
                end
                default: state_q <= ST_HOLD;
            endcase
        end
    end

    assign mem_rd_en = (state_q == ST_READ);
    assign mem_addr  = addr_q;

    for (genvar i = 0; i < NUM_BUS; i++) begin : g_out
        // Present data and ready on the connected bus only.
        assign bus_ready[i] = rdy_q && (sel_q == IW'(i));
        assign bus_rdata[i*DATA_W +: DATA_W] = bus_ready[i] ? data_q : '0;
    end
endmodule

// File: rtl/mps_checker.sv
// Property checker for mem_port_selector, attached by bind below.
// Assumes inputs change only between clock edges.
module mps_checker #(
    parameter int NB          = 4,
    parameter int DW          = 16,
    parameter int IW          = 2,
    parameter int TIMEOUT_CYC = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NB-1:0]          bus_req,
    input  logic [NB-1:0]          bus_ready,
    input  logic [NB*DW-1:0]       bus_rdata,
    input  logic                   mem_rd_en,
    input  mps_pkg::mps_state_e    state,
    input  logic [IW-1:0]          sel,
    input  logic [NB-1:0]          lock
);
    localparam int RW = $clog2(TIMEOUT_CYC + 2) + 1;
    logic [RW-1:0] busy_run;

    // Length of the current busy stretch, observed independently of the guard.
    always_ff @(posedge clk) begin
        if (!rst_n)                        busy_run <= '0;
        else if (state != mps_pkg::ST_SCAN) busy_run <= busy_run + 1'b1;
        else                               busy_run <= '0;
    end

    assert_ready_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_ready));

    assert_ready_after_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_ready & ~$past(bus_req)) == '0));

    assert_single_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    assert_read_from_scan_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> $past(state == mps_pkg::ST_SCAN));

    assert_busy_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= RW'(TIMEOUT_CYC));

    assert_no_locked_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> !lock[sel]);

    assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ready != '0 && $past(bus_ready) == bus_ready) |-> $stable(bus_rdata));
endmodule

bind mem_port_selector mps_checker #(
    .NB(NUM_BUS), .DW(DATA_W), .IW(IW), .TIMEOUT_CYC(TIMEOUT_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_ready (bus_ready),
    .bus_rdata (bus_rdata),
    .mem_rd_en (mem_rd_en),
    .state     (state_q),
    .sel       (sel_q),
    .lock      (lock_q)
);

// File: tb/mem_port_selector_tb.sv
// Directed bench for mem_port_selector: one task per scenario.
module mem_port_selector_tb;
    localparam int NB = 4, IDW = 3, AW = 8, DW = 16, TO = 16;
    localparam logic [IDW-1:0] MY_ID = 3'd5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NB-1:0]     bus_req = '0;
    logic [NB*IDW-1:0] bus_mem_id = '0;
    logic [NB*AW-1:0]  bus_addr = '0;
    logic [NB*DW-1:0]  bus_rdata;
    logic [NB-1:0]     bus_ready;
    logic              mem_rd_en;
    logic [AW-1:0]     mem_addr;
    logic [DW-1:0]     mem_rdata = '0;

    int checks = 0, errors = 0, rd_cnt = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    mem_port_selector #(.NUM_BUS(NB), .ID_W(IDW), .ADDR_W(AW), .DATA_W(DW),
                        .TIMEOUT_CYC(TO), .LOCKOUT_EN(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .my_id(MY_ID), .bus_req(bus_req),
        .bus_mem_id(bus_mem_id), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata)
    );

    // Local memory model: one-cycle latency, word = {addr, ~addr}.
    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= {mem_addr, ~mem_addr};
        if (rst_n && mem_rd_en) rd_cnt <= rd_cnt + 1;
    end

    function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
        return {a, ~a};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_req = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic set_bus(input int b, input logic [IDW-1:0] id, input logic [AW-1:0] a);
        bus_mem_id[b*IDW +: IDW] = id;
        bus_addr[b*AW +: AW] = a;
    endtask

    // Wait at falling edges until bus b shows ready; n = edges waited (max+1 if never).
    task automatic wait_ready(input int b, input int max, output int n);
        n = max + 1;
        for (int k = 1; k <= max; k++) begin
            @(posedge clk); @(negedge clk);
            if (bus_ready[b]) begin n = k; break; end
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(bus_ready == '0, "R1 ready", 64'(bus_ready), 0);
        chk(bus_rdata == '0, "R1 data", 64'(bus_rdata), 0);
        chk(mem_rd_en == 1'b0, "R1 strobe", 64'(mem_rd_en), 0);
    endtask

    task automatic t_basic();
        int n, r0;
        r0 = rd_cnt;
        set_bus(0, MY_ID, 8'h5A);
        @(negedge clk); bus_req[0] = 1'b1;
        wait_ready(0, 8, n);
        chk(n == 3, "R3 latency", 64'(n), 3);
        chk(bus_rdata[0 +: DW] == word_of(8'h5A), "R3 data", 64'(bus_rdata[0 +: DW]), 64'(word_of(8'h5A)));
        chk(bus_ready == 4'b0001, "R5 only served bus ready", 64'(bus_ready), 1);
        chk(bus_rdata[NB*DW-1:DW] == '0, "R5 others data zero", 64'(bus_rdata[NB*DW-1:DW]), 0);
        repeat (4) @(negedge clk);
        chk(bus_ready[0] && bus_rdata[0 +: DW] == word_of(8'h5A), "R5 hold", 64'(bus_rdata[0 +: DW]), 64'(word_of(8'h5A)));
        chk(rd_cnt - r0 == 1, "R4 one read", 64'(rd_cnt - r0), 1);
        bus_req[0] = 1'b0;
        @(negedge clk);
        chk(bus_ready == '0, "R6 drop", 64'(bus_ready), 0);
    endtask

    task automatic t_mismatch();
        int n, r0;
        r0 = rd_cnt;
        set_bus(3, MY_ID + 3'd1, 8'h11);
        @(negedge clk); bus_req[3] = 1'b1;
        wait_ready(3, 8, n);
        chk(n == 9, "R2 no answer to other id", 64'(n), 9);
        chk(rd_cnt == r0, "R2 no read", 64'(rd_cnt - r0), 0);
        bus_req[3] = 1'b0;
    endtask

    task automatic t_latch();
        int n;
        set_bus(2, MY_ID, 8'h33);
        @(negedge clk); bus_req[2] = 1'b1;
        @(negedge clk); bus_addr[2*AW +: AW] = 8'h44;
        wait_ready(2, 8, n);
        chk(n == 2, "R3 latency bus2", 64'(n), 2);
        chk(bus_rdata[2*DW +: DW] == word_of(8'h33), "R4 address latched", 64'(bus_rdata[2*DW +: DW]), 64'(word_of(8'h33)));
        bus_req[2] = 1'b0;
        @(negedge clk);
    endtask

    task automatic serve_expect(input int b, input string tag);
        int n;
        wait_ready(b, 8, n);
        chk(n <= 8 && bus_ready == NB'(1 << b), tag, 64'(bus_ready), 64'(1 << b));
        bus_req[b] = 1'b0;
    endtask

    task automatic t_round_robin();
        set_bus(0, MY_ID, 8'h01); set_bus(1, MY_ID, 8'h02); set_bus(3, MY_ID, 8'h04);
        @(negedge clk); bus_req = 4'b1011;
        serve_expect(3, "R7 first after last=2 is bus3");
        serve_expect(0, "R7 wrap to bus0");
        serve_expect(1, "R7 then bus1");
        @(negedge clk);
    endtask

    task automatic t_timeout();
        int n, r0;
        set_bus(1, MY_ID, 8'h77);
        @(negedge clk); bus_req[1] = 1'b1;
        wait_ready(1, 8, n);
        chk(n == 3, "R8 served before timeout", 64'(n), 3);
        repeat (14) @(negedge clk);
        chk(bus_ready == '0, "R8 released after timeout", 64'(bus_ready), 0);
        r0 = rd_cnt;
        repeat (10) @(negedge clk);
        chk(bus_ready == '0 && rd_cnt == r0, "R9 locked bus ignored", 64'(rd_cnt - r0), 0);
        bus_req[1] = 1'b0;
        @(negedge clk); bus_req[1] = 1'b1;
        repeat (6) @(negedge clk);
        chk(bus_ready == '0, "R9 re-request ignored", 64'(bus_ready), 0);
        set_bus(2, MY_ID, 8'h99);
        bus_req[2] = 1'b1;
        serve_expect(2, "R9 other bus still served");
        bus_req[1] = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_unlock();
        int n;
        do_reset();
        set_bus(1, MY_ID, 8'hC3);
        @(negedge clk); bus_req[1] = 1'b1;
        wait_ready(1, 8, n);
        chk(n == 3 && bus_rdata[DW +: DW] == word_of(8'hC3), "R10 reset clears lockout", 64'(bus_rdata[DW +: DW]), 64'(word_of(8'hC3)));
        bus_req[1] = 1'b0;
    endtask

    initial begin
        do_reset();
        t_reset();
        t_basic();
        t_mismatch();
        t_latch();
        t_round_robin();
        t_timeout();
        t_unlock();
        repeat (2) @(negedge clk);
        finish_up();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_up();
    end
endmodule